// File: doc/BRIEF.md
# Reset Manager Control Registers

This block is the software-visible register set of a reset manager. It keeps a sticky record of why the device was last reset: one flag per cause, set by a single-cycle hardware event pulse and cleared only when software writes a one to it. Several causes can be recorded at once, and a new event adds to the flags already set.

It also drives two active-low software reset requests, one for an SPI device and one for a USB block. Each request has a control bit, and each control bit has its own write-enable bit. Software can only turn a write-enable off, by writing a one to it. Once it is off, writes to that peripheral's control bit are dropped until the next block reset, so firmware can fix a peripheral's reset state for good.

Access is through a plain 32-bit register port with valid, write, address and data signals. Read data returns one cycle after the read request, marked by a read-valid strobe.

Top module: `rstctl_regs`

## Requirements
- R1: After reset the reset-reason register reads 0x00000001, both write-enable registers and both control registers read 0x00000001, `spi_rst_n` and `usb_rst_n` are 1, and `bus_rvalid` is 0.
- R2: A pulse on bit i of `cause_evt` sets bit i of the reset-reason register (offset 0x00) at the next clock edge and leaves the other bits as they were. The bits are: 0 power-on, 1 low-power exit, 2 watchdog, 3 security escalation, 4 non-debug-module request. Several bits may pulse together.
- R3: Writing the reset-reason register clears each bit of bits [4:0] where the write data has a 1, and leaves bits written with 0 unchanged. If a bit is cleared and receives an event pulse in the same cycle, it ends up set.
- R4: The SPI write-enable (offset 0x04, bit 0) and the USB write-enable (offset 0x08, bit 0) are cleared by writing 1 to bit 0. Writing 0 has no effect. Once cleared, a write-enable stays 0 until the block is reset.
- R5: The SPI control (offset 0x0C, bit 0) and the USB control (offset 0x10, bit 0) take bit 0 of the write data when their write-enable is 1. `spi_rst_n` and `usb_rst_n` equal the SPI and USB control bits and change at the clock edge that captures the write.
- R6: While a peripheral's write-enable is 0, writes to its control register are ignored and its reset output holds.
- R7: A read request (`bus_valid`=1, `bus_write`=0) sets `bus_rvalid` to 1 for exactly one cycle, one cycle later, with the addressed register in `bus_rdata`. Unused bits read as 0, and addresses other than 0x00, 0x04, 0x08, 0x0C and 0x10 read as 0.
- R8: Writes to unmapped addresses change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read request |
| bus_rdata | output | 32 | Read data |
| cause_evt | input | 5 | Single-cycle reset-cause event pulses |
| spi_rst_n | output | 1 | Active-low software reset request to the SPI device |
| usb_rst_n | output | 1 | Active-low software reset request to the USB block |

## Verification
The bench puts a clear and a set of the same cause bit in one cycle. A design that gave the clear priority would lose a fresh reset reason. It writes zeros to the cause and write-enable registers: a design that wrote these registers directly, rather than clearing on ones, would wipe flags or reopen a lock. After locking SPI, it checks that SPI control writes are ignored while USB stays writable, so a design that shared one lock or let a control write get past it would move the wrong reset output. Reads of unmapped addresses, a write to an unmapped address and a second reset check that a stray write corrupts nothing, that unmapped space reads as zero and that the locks reopen only on reset.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 5;
    localparam int unsigned CAUSE_W  = 5;
    localparam int unsigned N_PERIPH = 2;

    // peripheral indices
    localparam int unsigned PERIPH_SPI = 0;
    localparam int unsigned PERIPH_USB = 1;

    // cause flag positions (decoded by software)
    localparam int unsigned CAUSE_POWER_ON  = 0;
    localparam int unsigned CAUSE_LP_EXIT   = 1;
    localparam int unsigned CAUSE_WATCHDOG  = 2;
    localparam int unsigned CAUSE_ESCALATE  = 3;
    localparam int unsigned CAUSE_NDM_REQ   = 4;

    typedef struct packed {
        logic en;
        logic ctl;
    } gate_state_t;

endpackage

// File: rtl/rstctl_cause_rec.sv
module rstctl_cause_rec #(
    parameter int unsigned CAUSE_W   = rstctl_pkg::CAUSE_W,
    parameter logic [CAUSE_W-1:0] RESET_VAL = CAUSE_W'(1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] evt_i,
    input  logic               clr_we_i,
    input  logic [CAUSE_W-1:0] clr_mask_i,
    output logic [CAUSE_W-1:0] cause_o
);

    typedef struct packed {
        logic [CAUSE_W-1:0] flags;
    } cause_state_t;

    cause_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_we_i) begin
            st_d.flags = st_d.flags & ~clr_mask_i;
        end
        // a hardware event overrides a clear in the same cycle
        st_d.flags = st_d.flags | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flags <= RESET_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_o = st_q.flags;

    // R2: every pulsed cause is recorded at the next edge
    a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((cause_o & $past(evt_i)) == $past(evt_i)));

    // R3: without a clear, no flag ever drops
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we_i |=> ((cause_o & $past(cause_o)) == $past(cause_o)));

    // R3: a cleared bit with no competing event reads 0 afterwards
    a_r3_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((cause_o & $past(clr_mask_i & ~evt_i)) == '0));

endmodule

// File: rtl/rstctl_sw_gate.sv
module rstctl_sw_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_we_i,
    input  logic ctl_we_i,
    input  logic wbit_i,
    output logic en_o,
    output logic ctl_o
);
    import rstctl_pkg::*;

    gate_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // write-one-to-clear enable: can only fall
        if (lock_we_i && wbit_i) begin
            st_d.en = 1'b0;
        end
        if (ctl_we_i && st_q.en) begin
            st_d.ctl = wbit_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en  <= 1'b1;
            st_q.ctl <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o  = st_q.en;
    assign ctl_o = st_q.ctl;

    // R4: once off, the enable stays off until reset
    a_r4_lock_oneway: assert property (@(posedge clk) disable iff (!rst_n)
        !en_o |=> !en_o);

    // R6: a locked control bit never moves
    a_r6_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en_o |=> $stable(ctl_o));

    // R5: an enabled control write is captured
    a_r5_write_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we_i && en_o) |=> (ctl_o == $past(wbit_i)));

endmodule

// File: rtl/rstctl_regs.sv
module rstctl_regs #(
    parameter int unsigned DATA_W  = rstctl_pkg::DATA_W,
    parameter int unsigned ADDR_W  = rstctl_pkg::ADDR_W,
    parameter int unsigned CAUSE_W = rstctl_pkg::CAUSE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic               bus_rvalid,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [CAUSE_W-1:0] cause_evt,
    output logic               spi_rst_n,
    output logic               usb_rst_n
);
    import rstctl_pkg::*;

    localparam int unsigned NP        = N_PERIPH;
    localparam int unsigned WORD_B    = DATA_W / 8;
    localparam int unsigned EN_BASE   = WORD_B;
    localparam int unsigned CTL_BASE  = WORD_B * (1 + NP);
    localparam logic [ADDR_W-1:0] CAUSE_OFS = '0;

    function automatic logic [ADDR_W-1:0] en_ofs(input int unsigned idx);
        return ADDR_W'(EN_BASE + WORD_B * idx);
    endfunction

    function automatic logic [ADDR_W-1:0] ctl_ofs(input int unsigned idx);
        return ADDR_W'(CTL_BASE + WORD_B * idx);
    endfunction

    typedef struct packed {
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    logic               wr_req, rd_req;
    logic               cause_clr_we;
    logic [CAUSE_W-1:0] cause_q;
    logic [NP-1:0]      lock_we, ctl_we, en_w, ctl_w;
    logic [DATA_W-1:0]  rd_word;
    rd_state_t          rd_d, rd_q;
    logic               unused_wdata;

    assign wr_req       = bus_valid && bus_write;
    assign rd_req       = bus_valid && !bus_write;
    assign cause_clr_we = wr_req && (bus_addr == CAUSE_OFS);
    assign unused_wdata = ^bus_wdata[DATA_W-1:CAUSE_W];

    rstctl_cause_rec #(
        .CAUSE_W   (CAUSE_W),
        .RESET_VAL (CAUSE_W'(1) << CAUSE_POWER_ON)
    ) u_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (cause_evt),
        .clr_we_i   (cause_clr_we),
        .clr_mask_i (bus_wdata[CAUSE_W-1:0]),
        .cause_o    (cause_q)
    );

    for (genvar gi = 0; gi < NP; gi++) begin : g_periph
        assign lock_we[gi] = wr_req && (bus_addr == en_ofs(gi));
        assign ctl_we[gi]  = wr_req && (bus_addr == ctl_ofs(gi));

        rstctl_sw_gate u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .lock_we_i (lock_we[gi]),
            .ctl_we_i  (ctl_we[gi]),
            .wbit_i    (bus_wdata[0]),
            .en_o      (en_w[gi]),
            .ctl_o     (ctl_w[gi])
        );
    end

    // readback decode
    always_comb begin
        rd_word = '0;
        if (bus_addr == CAUSE_OFS) begin
            rd_word[CAUSE_W-1:0] = cause_q;
        end
        for (int i = 0; i < int'(NP); i++) begin
            if (bus_addr == en_ofs(i))  rd_word[0] = en_w[i];
            if (bus_addr == ctl_ofs(i)) rd_word[0] = ctl_w[i];
        end
    end

    always_comb begin
        rd_d        = rd_q;
        rd_d.rvalid = rd_req;
        if (rd_req) begin
            rd_d.rdata = rd_word;
        end else begin
            rd_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rvalid = rd_q.rvalid;
    assign bus_rdata  = rd_q.rdata;
    assign spi_rst_n  = ctl_w[PERIPH_SPI];
    assign usb_rst_n  = ctl_w[PERIPH_USB];

    // R7: each read request yields one read-valid cycle
    a_r7_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);

    // R7: no read-valid without a request
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !bus_rvalid);

    // R8: a write outside the map leaves both reset outputs alone
    a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !(|ctl_we)) |=> ($stable(spi_rst_n) && $stable(usb_rst_n)));

endmodule

// File: tb/rstctl_regs_tb.sv
module rstctl_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic [4:0]  cause_evt = '0;
    logic        spi_rst_n, usb_rst_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    rstctl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .cause_evt(cause_evt),
        .spi_rst_n(spi_rst_n), .usb_rst_n(usb_rst_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // driver: issue a read and push the expected word
    task automatic do_read(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic do_write(input logic [4:0] a, input logic [31:0] d, input logic [4:0] evt);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; cause_evt = evt;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; cause_evt = '0;
    endtask

    task automatic pulse(input logic [4:0] evt);
        @(negedge clk);
        cause_evt = evt;
        @(negedge clk);
        cause_evt = '0;
    endtask

    // monitor: compare each returned word against the scoreboard
    always @(posedge clk) begin
        #1;
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R7: unexpected read-valid, actual 0x%08h expected none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rvalid idle", 32'(bus_rvalid), 0);
        check("R1 spi_rst_n", 32'(spi_rst_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 usb_rst_n", 32'(usb_rst_n), 1);
        check("R1 rvalid after release", 32'(bus_rvalid), 0);
        do_read(5'h00, 32'h1, "R1 cause reset");
        do_read(5'h04, 32'h1, "R1 spi enable reset");
        do_read(5'h08, 32'h1, "R1 usb enable reset");
        do_read(5'h0C, 32'h1, "R1 spi ctl reset");
        do_read(5'h10, 32'h1, "R1 usb ctl reset");

        // R2 capture
        pulse(5'h04);
        do_read(5'h00, 32'h05, "R2 watchdog ORs in");
        pulse(5'h12);
        do_read(5'h00, 32'h17, "R2 two causes together");

        // R3 write-one-to-clear
        do_write(5'h00, 32'h04, 5'h00);
        do_read(5'h00, 32'h13, "R3 clear watchdog");
        do_write(5'h00, 32'h0, 5'h00);
        do_read(5'h00, 32'h13, "R3 zero write keeps");
        do_write(5'h00, 32'h10, 5'h10);
        do_read(5'h00, 32'h13, "R3 set wins over clear");
        do_write(5'h00, 32'hFFFF_FFFF, 5'h00);
        do_read(5'h00, 32'h0, "R3 clear all");
        pulse(5'h08);
        do_read(5'h00, 32'h08, "R2 escalation alone");

        // R5 control while enabled
        do_write(5'h0C, 32'h0, 5'h00);
        check("R5 spi held", 32'(spi_rst_n), 0);
        check("R5 usb untouched", 32'(usb_rst_n), 1);
        do_read(5'h0C, 32'h0, "R5 spi ctl readback");
        do_write(5'h0C, 32'h1, 5'h00);
        check("R5 spi released", 32'(spi_rst_n), 1);

        // R4 lock
        do_write(5'h04, 32'h0, 5'h00);
        do_read(5'h04, 32'h1, "R4 zero write no effect");
        do_write(5'h04, 32'h1, 5'h00);
        do_read(5'h04, 32'h0, "R4 spi enable cleared");
        do_write(5'h04, 32'h0, 5'h00);
        do_read(5'h04, 32'h0, "R4 stays cleared");

        // R6 locked writes ignored
        do_write(5'h0C, 32'h0, 5'h00);
        check("R6 spi output holds", 32'(spi_rst_n), 1);
        do_read(5'h0C, 32'h1, "R6 spi ctl holds");
        do_write(5'h10, 32'h0, 5'h00);
        check("R5 usb still writable", 32'(usb_rst_n), 0);
        do_write(5'h08, 32'h1, 5'h00);
        do_write(5'h10, 32'h1, 5'h00);
        check("R6 usb output holds", 32'(usb_rst_n), 0);
        do_read(5'h10, 32'h0, "R6 usb ctl holds");

        // R7 / R8 unmapped
        do_read(5'h14, 32'h0, "R7 unmapped 0x14");
        do_read(5'h1C, 32'h0, "R7 unmapped 0x1C");
        do_write(5'h14, 32'hFFFF_FFFF, 5'h00);
        check("R8 spi after stray write", 32'(spi_rst_n), 1);
        check("R8 usb after stray write", 32'(usb_rst_n), 0);
        do_read(5'h00, 32'h08, "R8 cause intact");
        do_read(5'h08, 32'h0, "R8 usb enable intact");

        // R4 reopen only on reset
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_read(5'h04, 32'h1, "R4 spi enable after reset");
        do_read(5'h08, 32'h1, "R4 usb enable after reset");
        check("R1 usb out after reset", 32'(usb_rst_n), 1);

        repeat (3) @(negedge clk);
        check("R7 all reads returned", 32'(exp_q.size()), 0);
        finish_run();
    end

endmodule